// File: doc/BRIEF.md
# Two-Event Classification Result Resolver

This block turns the coded outcome of one or two classification measurements on a single powered port into the final 4-bit class status of that port. A measurement sequencer pulses a start strobe, then returns each raw result with a one-cycle done strobe. The resolver decides whether a second measurement is needed and asks for it. It then merges the results into one status code and reports that code with a one-cycle valid pulse. When the outcome is unusable for powering the port, it also pulses a start-fault flag.

The status code stays on `cls_code_o` until the next completed classification or until the port is switched off, which clears it. A level output tells the automatic power-up logic whether the latest result allows automatic power-on. An explicit power-on command elsewhere in the chip is not gated by this block. Raw results arrive already coded. Reserved and out-of-range raw values are normalized before any decision is taken.

Top module: `class_result_resolver`

## Requirements
- R1: After reset, `cls_code_o` is 0000 and `valid_o`, `fault_o`, `second_req_o` and `auto_pwr_ok_o` are all low.
- R2: A raw code of 0101 is treated as class 0 (0110), and raw codes 1000 to 1111 are treated as unknown (0000), before any comparison or output.
- R3: When the two-event enable sampled with the start strobe is low, the final code equals the normalized first result.
- R4: When the normalized first result is overcurrent (0111), the final code is 0111 and `second_req_o` stays low, whatever the two-event enable is.
- R5: With two-event classification enabled and a first result other than overcurrent, `second_req_o` pulses high for exactly one cycle, in the cycle after the first done strobe.
- R6: When the normalized second result is overcurrent, the final code is 0111.
- R7: When the normalized second result is not overcurrent, the final code is class mismatch (1000) if it differs from the normalized first result, and that common code if the two are equal.
- R8: `fault_o` is high in the cycle of `valid_o` exactly when the final code is 0111 or 1000, and it is never high at any other time.
- R9: `valid_o` is high for exactly one cycle, the cycle after the done strobe that completes the classification, and `cls_code_o` already holds the new code in that cycle and keeps it afterwards.
- R10: `port_off_i` clears `cls_code_o` to 0000 and `auto_pwr_ok_o` low on the next cycle and aborts a classification in progress, so no valid pulse follows for it.
- R11: `auto_pwr_ok_o` is high only while `auto_mode_i` is high and the latest final code is 0001 to 0100 or 0110. An accepted start strobe clears it.
- R12: A start strobe while a classification is in progress, and a done strobe while idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a classification when idle |
| two_evt_en_i | input | 1 | Two-event classification enable, sampled with start |
| auto_mode_i | input | 1 | Port is in automatic mode |
| port_off_i | input | 1 | Port turned off: clear status and abort |
| raw_done_i | input | 1 | One-cycle strobe: raw result present |
| raw_code_i | input | 4 | Raw coded classification result |
| second_req_o | output | 1 | One-cycle request to run the second event |
| cls_code_o | output | 4 | Final class status code |
| valid_o | output | 1 | One-cycle pulse: new final code |
| fault_o | output | 1 | One-cycle start-fault pulse |
| auto_pwr_ok_o | output | 1 | Automatic power-on permitted |

## Verification
The bench sweeps every pair of raw codes, including reserved and out-of-range values. It computes the merged code arithmetically. A resolver that compared before normalizing would report mismatch for a 0101/0110 pair, and one that let a raw 1000 through would produce mismatch from a single event. A first-event overcurrent must never be followed by a second-event request; a design that missed this would hang the sequencer or overwrite the overcurrent result. Aborting by port-off in the middle of a sequence, a restart strobe during the second event, and a stray done while idle are also aimed at, since a design that mishandled any of them would publish a stale or misattributed code.

// File: rtl/cls_resolve_pkg.sv
package cls_resolve_pkg;

   localparam int CLS_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT_FIRST,
      ST_WAIT_SECOND,
      ST_DONE
   } cls_state_e;

   localparam logic [CLS_W-1:0] CODE_UNKNOWN  = 4'b0000;
   localparam logic [CLS_W-1:0] CODE_CLASS4   = 4'b0100;
   localparam logic [CLS_W-1:0] CODE_RSVD     = 4'b0101;
   localparam logic [CLS_W-1:0] CODE_CLASS0   = 4'b0110;
   localparam logic [CLS_W-1:0] CODE_OVERCUR  = 4'b0111;
   localparam logic [CLS_W-1:0] CODE_MISMATCH = 4'b1000;

   function automatic logic cls_is_bad(input logic [CLS_W-1:0] code);
      return (code == CODE_OVERCUR) || (code == CODE_MISMATCH);
   endfunction

   function automatic logic cls_is_powerable(input logic [CLS_W-1:0] code);
      return ((code != CODE_UNKNOWN) && (code <= CODE_CLASS4)) || (code == CODE_CLASS0);
   endfunction

endpackage

// File: rtl/cls_code_norm.sv
module cls_code_norm
   import cls_resolve_pkg::*;
#(
   parameter int CODE_W         = 4,
   parameter bit RSVD_AS_CLASS0 = 1'b1
) (
   input  logic [CODE_W-1:0] raw_i,
   output logic [CODE_W-1:0] norm_i_o
);

   localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CODE_MISMATCH);

   logic [CODE_W-1:0] ranged;

   always_comb begin
      if (raw_i >= LIMIT) ranged = CODE_W'(CODE_UNKNOWN);
      else                ranged = raw_i;
   end

   generate
      if (RSVD_AS_CLASS0) begin : g_map_rsvd
         always_comb begin
            if (ranged == CODE_W'(CODE_RSVD)) norm_i_o = CODE_W'(CODE_CLASS0);
            else                              norm_i_o = ranged;
         end
      end else begin : g_keep_rsvd
         always_comb norm_i_o = ranged;
      end
   endgenerate

endmodule

// File: rtl/cls_outcome_judge.sv
module cls_outcome_judge
   import cls_resolve_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] first_i,
   input  logic [CODE_W-1:0] second_i,
   output logic [CODE_W-1:0] merged_o
);

   always_comb begin
      if (second_i == CODE_W'(CODE_OVERCUR))
         merged_o = CODE_W'(CODE_OVERCUR);
      else if (second_i != first_i)
         merged_o = CODE_W'(CODE_MISMATCH);
      else
         merged_o = second_i;
   end

endmodule

// File: rtl/cls_seq_fsm.sv
module cls_seq_fsm
   import cls_resolve_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter bit TWO_EVT_SUP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              two_en_i,
   input  logic              off_i,
   input  logic              done_i,
   input  logic [CODE_W-1:0] norm_i,
   input  logic [CODE_W-1:0] merged_i,
   output logic [CODE_W-1:0] first_o,
   output logic              req_o,
   output logic              accept_o,
   output logic              commit_o,
   output logic [CODE_W-1:0] commit_val_o,
   output logic              in_done_o
);

   cls_state_e        state_q;
   logic              two_q;
   logic [CODE_W-1:0] first_q;
   logic              req_q;
   logic              two_cap;
   logic              need_second;

   generate
      if (TWO_EVT_SUP) begin : g_two
         assign two_cap = two_en_i;
      end else begin : g_one
         logic unused_two;
         assign unused_two = two_en_i;
         assign two_cap    = 1'b0;
      end
   endgenerate

   assign need_second = two_q && (norm_i != CODE_W'(CODE_OVERCUR));
   assign accept_o    = !off_i && start_i && (state_q == ST_IDLE);

   always_comb begin
      commit_o     = 1'b0;
      commit_val_o = norm_i;
      if (!off_i && done_i) begin
         if (state_q == ST_WAIT_FIRST && !need_second) begin
            commit_o     = 1'b1;
            commit_val_o = norm_i;
         end else if (state_q == ST_WAIT_SECOND) begin
            commit_o     = 1'b1;
            commit_val_o = merged_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         two_q   <= 1'b0;
         first_q <= '0;
         req_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (off_i) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (start_i) begin
                     state_q <= ST_WAIT_FIRST;
                     two_q   <= two_cap;
                  end
               end
               ST_WAIT_FIRST: begin
                  if (done_i) begin
                     first_q <= norm_i;
                     if (need_second) begin
                        state_q <= ST_WAIT_SECOND;
                        req_q   <= 1'b1;
                     end else begin
                        state_q <= ST_DONE;
                     end
                  end
               end
               ST_WAIT_SECOND: begin
                  if (done_i) state_q <= ST_DONE;
               end
               ST_DONE: state_q <= ST_IDLE;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign first_o   = first_q;
   assign req_o     = req_q;
   assign in_done_o = (state_q == ST_DONE);

endmodule

// File: rtl/class_result_resolver.sv
module class_result_resolver
   import cls_resolve_pkg::*;
#(
   parameter int CODE_W         = 4,
   parameter bit TWO_EVT_SUP    = 1'b1,
   parameter bit RSVD_AS_CLASS0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              two_evt_en_i,
   input  logic              auto_mode_i,
   input  logic              port_off_i,
   input  logic              raw_done_i,
   input  logic [CODE_W-1:0] raw_code_i,
   output logic              second_req_o,
   output logic [CODE_W-1:0] cls_code_o,
   output logic              valid_o,
   output logic              fault_o,
   output logic              auto_pwr_ok_o
);

   generate
      if (CODE_W != CLS_W) begin : g_bad_width
         $error("class_result_resolver: CODE_W must equal the status code width");
      end
   endgenerate

   logic [CODE_W-1:0] norm_code;
   logic [CODE_W-1:0] first_code;
   logic [CODE_W-1:0] merged_code;
   logic [CODE_W-1:0] commit_val;
   logic              commit;
   logic              accept;
   logic              in_done;
   logic [CODE_W-1:0] code_q;
   logic              grant_q;

   cls_code_norm #(
      .CODE_W         (CODE_W),
      .RSVD_AS_CLASS0 (RSVD_AS_CLASS0)
   ) u_norm (
      .raw_i    (raw_code_i),
      .norm_i_o (norm_code)
   );

   cls_outcome_judge #(
      .CODE_W (CODE_W)
   ) u_judge (
      .first_i  (first_code),
      .second_i (norm_code),
      .merged_o (merged_code)
   );

   cls_seq_fsm #(
      .CODE_W      (CODE_W),
      .TWO_EVT_SUP (TWO_EVT_SUP)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .two_en_i     (two_evt_en_i),
      .off_i        (port_off_i),
      .done_i       (raw_done_i),
      .norm_i       (norm_code),
      .merged_i     (merged_code),
      .first_o      (first_code),
      .req_o        (second_req_o),
      .accept_o     (accept),
      .commit_o     (commit),
      .commit_val_o (commit_val),
      .in_done_o    (in_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         grant_q <= 1'b0;
      end else if (port_off_i) begin
         code_q  <= '0;
         grant_q <= 1'b0;
      end else if (commit) begin
         code_q  <= commit_val;
         grant_q <= cls_is_powerable(commit_val);
      end else if (accept) begin
         grant_q <= 1'b0;
      end
   end

   assign cls_code_o    = code_q;
   assign valid_o       = in_done;
   assign fault_o       = in_done && cls_is_bad(code_q);
   assign auto_pwr_ok_o = grant_q && auto_mode_i;

endmodule

// File: rtl/class_result_resolver_chk.sv
module class_result_resolver_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              raw_done_i,
   input logic [CODE_W-1:0] raw_code_i,
   input logic              port_off_i,
   input logic              second_req_o,
   input logic [CODE_W-1:0] cls_code_o,
   input logic              valid_o,
   input logic              fault_o,
   input logic              auto_pwr_ok_o
);

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R9

   AST_FAULT_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (valid_o && (cls_code_o == CODE_W'(7) || cls_code_o == CODE_W'(8)))); // R8

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      port_off_i |=> (cls_code_o == '0 && !valid_o && !auto_pwr_ok_o)); // R10

   AST_REQ_AFTER_GOOD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      second_req_o |-> ($past(raw_done_i) && $past(raw_code_i) != CODE_W'(7))); // R4

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      second_req_o |=> !second_req_o); // R5

   AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(raw_done_i)); // R12

   AST_NO_AUTO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pwr_ok_o |-> !(cls_code_o == '0 || cls_code_o == CODE_W'(7) || cls_code_o == CODE_W'(8))); // R11

endmodule

bind class_result_resolver class_result_resolver_chk #(.CODE_W(CODE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .raw_done_i    (raw_done_i),
   .raw_code_i    (raw_code_i),
   .port_off_i    (port_off_i),
   .second_req_o  (second_req_o),
   .cls_code_o    (cls_code_o),
   .valid_o       (valid_o),
   .fault_o       (fault_o),
   .auto_pwr_ok_o (auto_pwr_ok_o)
);

// File: tb/class_result_resolver_tb.sv
`timescale 1ns/1ps
module class_result_resolver_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       two_evt_en_i = 1'b0;
   logic       auto_mode_i = 1'b1;
   logic       port_off_i = 1'b0;
   logic       raw_done_i = 1'b0;
   logic [3:0] raw_code_i = 4'd0;
   logic       second_req_o;
   logic [3:0] cls_code_o;
   logic       valid_o;
   logic       fault_o;
   logic       auto_pwr_ok_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   class_result_resolver u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .two_evt_en_i  (two_evt_en_i),
      .auto_mode_i   (auto_mode_i),
      .port_off_i    (port_off_i),
      .raw_done_i    (raw_done_i),
      .raw_code_i    (raw_code_i),
      .second_req_o  (second_req_o),
      .cls_code_o    (cls_code_o),
      .valid_o       (valid_o),
      .fault_o       (fault_o),
      .auto_pwr_ok_o (auto_pwr_ok_o)
   );

   function automatic logic [3:0] nrm(input logic [3:0] r);
      if (r >= 4'd8) return 4'd0;
      if (r == 4'd5) return 4'd6;
      return r;
   endfunction

   function automatic logic [3:0] expect_code(input logic two, input logic [3:0] a, input logic [3:0] b);
      logic [3:0] na, nb;
      na = nrm(a);
      nb = nrm(b);
      if (!two || na == 4'd7) return na;
      if (nb == 4'd7) return 4'd7;
      if (nb != na) return 4'd8;
      return nb;
   endfunction

   function automatic logic good(input logic [3:0] c);
      return (c >= 4'd1 && c <= 4'd4) || c == 4'd6;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_case(input logic two, input logic [3:0] a, input logic [3:0] b);
      logic [3:0] exp;
      logic       want_req;
      string      tag;
      exp      = expect_code(two, a, b);
      want_req = two && nrm(a) != 4'd7;
      if (!two)                      tag = "R3";
      else if (nrm(a) == 4'd7)       tag = "R4";
      else if (a >= 4'd5 && a != 4'd6 && a != 4'd7) tag = "R2";
      else if (b >= 4'd5 && b != 4'd6 && b != 4'd7) tag = "R2";
      else if (nrm(b) == 4'd7)       tag = "R6";
      else                           tag = "R7";
      @(negedge clk);
      start_i = 1'b1; two_evt_en_i = two;
      @(negedge clk);
      start_i = 1'b0; raw_done_i = 1'b1; raw_code_i = a;
      @(negedge clk);
      raw_done_i = 1'b0;
      if (want_req) begin
         chk("R5 req pulse", {7'd0, second_req_o}, 8'd1);
         chk("R9 no early valid", {7'd0, valid_o}, 8'd0);
         raw_done_i = 1'b1; raw_code_i = b;
         @(negedge clk);
         raw_done_i = 1'b0;
         chk("R5 req one cycle", {7'd0, second_req_o}, 8'd0);
      end else begin
         chk("R4 no second req", {7'd0, second_req_o}, 8'd0);
      end
      chk(tag, {4'd0, cls_code_o}, {4'd0, exp});
      chk("R9 valid", {7'd0, valid_o}, 8'd1);
      chk("R8 fault", {7'd0, fault_o}, {7'd0, (exp == 4'd7 || exp == 4'd8)});
      chk("R11 auto ok", {7'd0, auto_pwr_ok_o}, {7'd0, good(exp)});
      @(negedge clk);
      chk("R9 valid drop", {7'd0, valid_o}, 8'd0);
      chk("R8 fault drop", {7'd0, fault_o}, 8'd0);
      chk("R9 code held", {4'd0, cls_code_o}, {4'd0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 code", {4'd0, cls_code_o}, 8'd0);
      chk("R1 flags", {4'd0, valid_o, fault_o, second_req_o, auto_pwr_ok_o}, 8'd0);
      rst_n = 1'b1;

      for (int a = 0; a < 16; a++) run_case(1'b0, 4'(a), 4'd0);
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            if (nrm(4'(a)) == 4'd7 && b > 0) continue;
            run_case(1'b1, 4'(a), 4'(b));
         end

      // R11: automatic mode off hides a good result
      run_case(1'b0, 4'd2, 4'd0);
      @(negedge clk); auto_mode_i = 1'b0;
      @(negedge clk);
      chk("R11 manual mode", {7'd0, auto_pwr_ok_o}, 8'd0);
      auto_mode_i = 1'b1;
      @(negedge clk);
      chk("R11 auto restored", {7'd0, auto_pwr_ok_o}, 8'd1);
      start_i = 1'b1; two_evt_en_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      chk("R11 start clears", {7'd0, auto_pwr_ok_o}, 8'd0);
      raw_done_i = 1'b1; raw_code_i = 4'd3;
      @(negedge clk); raw_done_i = 1'b0;
      chk("R11 regranted", {7'd0, auto_pwr_ok_o}, 8'd1);

      // R10: port off in the middle of a two-event sequence
      @(negedge clk);
      start_i = 1'b1; two_evt_en_i = 1'b1;
      @(negedge clk); start_i = 1'b0; raw_done_i = 1'b1; raw_code_i = 4'd1;
      @(negedge clk); raw_done_i = 1'b0; port_off_i = 1'b1;
      @(negedge clk); port_off_i = 1'b0;
      chk("R10 code cleared", {4'd0, cls_code_o}, 8'd0);
      chk("R10 auto cleared", {7'd0, auto_pwr_ok_o}, 8'd0);
      raw_done_i = 1'b1; raw_code_i = 4'd1;
      @(negedge clk); raw_done_i = 1'b0;
      chk("R10 aborted no valid", {7'd0, valid_o}, 8'd0);
      chk("R10 code stays clear", {4'd0, cls_code_o}, 8'd0);

      // R12: done while idle is ignored
      run_case(1'b0, 4'd4, 4'd0);
      @(negedge clk); raw_done_i = 1'b1; raw_code_i = 4'd2;
      @(negedge clk); raw_done_i = 1'b0;
      chk("R12 idle done valid", {7'd0, valid_o}, 8'd0);
      chk("R12 idle done code", {4'd0, cls_code_o}, 8'd4);

      // R12: restart during second event is ignored
      @(negedge clk); start_i = 1'b1; two_evt_en_i = 1'b1;
      @(negedge clk); start_i = 1'b0; raw_done_i = 1'b1; raw_code_i = 4'd1;
      @(negedge clk); raw_done_i = 1'b0; start_i = 1'b1; two_evt_en_i = 1'b0;
      @(negedge clk); start_i = 1'b0; raw_done_i = 1'b1; raw_code_i = 4'd2;
      @(negedge clk); raw_done_i = 1'b0;
      chk("R12 busy start valid", {7'd0, valid_o}, 8'd1);
      chk("R12 busy start code", {4'd0, cls_code_o}, 8'd8);
      @(negedge clk);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule